// File: doc/BRIEF.md
# Two-Step Secret Provisioning Sequencer

This block runs the two-command flow that installs a device secret. The first command, "derive", takes a key selector and a 16-byte seed. It fetches the selected transport key from external key storage and forms a single 512-bit hash block. It then hands that block to an external SHA-256 engine through a level request and a one-cycle done pulse, and keeps the returned 256-bit digest as a one-shot mask. The second command, "install", XORs a 32-byte encrypted payload with that mask. It writes the result into a secret register that locks after its first write. Each command that this block owns gets a one-byte status reply.

Commands arrive already decoded from an upstream packet layer: an opcode, an 8-bit parameter, a 16-bit parameter and a 32-byte data field. The block sees every command that the layer accepts, including commands it does not own. A foreign command only cancels a pending mask, which enforces strict adjacency between derive and install. A watchdog expiry or a sleep request also discards the mask. Only a reset clears the lock on the secret. The secret has no read path. It is exposed only as a validity bit and as a port to a separate MAC path.

The controller is built around five states. IDLE accepts commands. FETCH presents the key selector and registers the hash block. HASH holds the request until the engine finishes. FLUSH waits out an abandoned hash. REPLY drives the status for one cycle. The transitions are:
- IDLE->FETCH on a well-formed derive.
- IDLE->REPLY on any owned command that completes at once.
- IDLE->IDLE on a foreign command.
- FETCH->HASH normally; FETCH->IDLE on watchdog or sleep.
- HASH->REPLY on done.
- HASH->FLUSH on watchdog or sleep before done; HASH->IDLE when done arrives together with the abort.
- FLUSH->IDLE on done.
- REPLY->IDLE always.

Top module: `kp_personalize_ctrl`

## Requirements
- R1: After reset, cmd_ready is 1 and busy, rsp_valid, sha_req and mem_valid are 0.
- R2: A derive (opcode 0x20, p1 = 0x00) drives key_id with p2 and raises sha_req. While sha_req is high, sha_msg carries these fields, from the MSB down:
  - bits 511:256 hold the key_data for that selector;
  - bits 255:192 are all ones;
  - bits 191:65 hold data bits 255:129, which are seed bytes 0..15 with byte i at data[255-8i -: 8] and the LSB of byte 15 dropped;
  - bit 64 is 1;
  - bits 63:0 hold the value 447.
- R3: From acceptance of a derive until its reply, busy is 1 and cmd_ready is 0. sha_req stays high until sha_done is seen, and every reply lasts exactly one cycle.
- R4: When sha_done arrives with no abort, the digest is kept and the mask-ready flag is set. A reply with status 0x00 follows in the next cycle.
- R5: An install (opcode 0x10, p1 = 0x00, p2 = 0x0000) returns 0x00 one cycle after acceptance when the mask is ready and the secret is unlocked. It sets mac_secret = data XOR digest, with byte i of each at bits [255-8i -: 8], and it sets mem_valid.
- R6: An install while no mask is ready returns 0x0F and leaves mem_valid and mac_secret unchanged.
- R7: Once mem_valid is set, an install returns 0x0F, and mac_secret and mem_valid keep their values through later commands, watchdog expiries and sleep requests.
- R8: Any other opcode is absorbed without a reply and discards a ready mask, so the next install returns 0x0F.
- R9: A derive with p1 != 0, or an install with p1 != 0 or p2 != 0, returns 0x03. It raises no hash request and keeps both the mask and the secret as they were.
- R10: wdt_expire or sleep_req discards a ready mask, so the next install returns 0x0F.
- R11: wdt_expire or sleep_req during FETCH or HASH abandons the derive. No reply is sent, the late digest is not kept, and cmd_ready returns once sha_done has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cmd_valid | input | 1 | Decoded command present (taken when cmd_ready) |
| cmd_opcode | input | 8 | Command opcode |
| cmd_p1 | input | 8 | First parameter |
| cmd_p2 | input | KEYID_W | Second parameter (key selector for derive) |
| cmd_data | input | 8*DATA_BYTES | Data field, byte 0 in the top byte |
| cmd_ready | output | 1 | Block can accept a command |
| busy | output | 1 | A derive is in flight |
| rsp_valid | output | 1 | One-cycle status reply strobe |
| rsp_status | output | 8 | Status: 0x00 ok, 0x03 bad parameter, 0x0F refused |
| key_id | output | KEYID_W | Selector presented to key storage |
| key_data | input | KEY_W | Transport key returned by key storage |
| sha_req | output | 1 | Hash request, held until sha_done |
| sha_msg | output | KEY_W+ONES_W+8*SEED_BYTES+LEN_W | Hash block presented with sha_req |
| sha_done | input | 1 | One-cycle hash completion pulse |
| sha_digest | input | 8*DATA_BYTES | Digest, valid with sha_done |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| sleep_req | input | 1 | Device entering sleep |
| mem_valid | output | 1 | Secret written and locked |
| mac_secret | output | 8*DATA_BYTES | Secret value towards the MAC datapath only |

## Verification
The bench builds the block with its default parameters: a 16-bit selector, a 256-bit key, a 16-byte seed and a 32-byte payload. It also sets the hash engine model's latency to six cycles. This latency makes the abort window inside HASH wide enough to hit, and it keeps every command short enough for complete sweeps. Those sweeps cover every foreign opcode between a derive and an install, every nonzero first parameter of a derive, and walking-one second parameters of an install. The message layout is checked against a computed block for eight selectors, each with both values of the dropped seed bit.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HASH,
        ST_FLUSH,
        ST_REPLY
    } kp_state_e;

    localparam logic [7:0] OP_DERIVE  = 8'h20;
    localparam logic [7:0] OP_INSTALL = 8'h10;

    localparam logic [7:0] STS_OK     = 8'h00;
    localparam logic [7:0] STS_PARAM  = 8'h03;
    localparam logic [7:0] STS_REFUSE = 8'h0F;
endpackage

// File: rtl/kp_msg_builder.sv
module kp_msg_builder #(
    parameter int KEY_W  = 256,
    parameter int ONES_W = 64,
    parameter int SEED_W = 128,
    parameter int LEN_W  = 64
) (
    input  logic [KEY_W-1:0]                       key,
    input  logic [SEED_W-2:0]                      seed_kept,
    output logic [KEY_W+ONES_W+SEED_W+LEN_W-1:0]   msg
);
    localparam int          BODY_BITS = KEY_W + ONES_W + SEED_W - 1;
    localparam logic [LEN_W-1:0] LEN_VAL = LEN_W'(BODY_BITS);

    always_comb begin
        msg = {key, {ONES_W{1'b1}}, seed_kept, 1'b1, LEN_VAL};
    end
endmodule

// File: rtl/kp_digest_store.sv
module kp_digest_store #(
    parameter int DIG_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [DIG_W-1:0] capture_val,
    input  logic             discard,
    output logic             ready,
    output logic [DIG_W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready <= 1'b0;
            value <= '0;
        end else if (discard) begin
            ready <= 1'b0;
            value <= '0;
        end else if (capture) begin
            ready <= 1'b1;
            value <= capture_val;
        end
    end
endmodule

// File: rtl/kp_secret_store.sv
module kp_secret_store #(
    parameter int SEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEC_W-1:0] wr_data,
    output logic             locked,
    output logic [SEC_W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b0;
            value  <= '0;
        end else if (wr_en && !locked) begin
            locked <= 1'b1;
            value  <= wr_data;
        end
    end
endmodule

// File: rtl/kp_personalize_ctrl.sv
module kp_personalize_ctrl
    import kp_pkg::*;
#(
    parameter int KEYID_W    = 16,
    parameter int KEY_W      = 256,
    parameter int SEED_BYTES = 16,
    parameter int DATA_BYTES = 32,
    parameter int ONES_W     = 64,
    parameter int LEN_W      = 64
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cmd_valid,
    input  logic [7:0]                                    cmd_opcode,
    input  logic [7:0]                                    cmd_p1,
    input  logic [KEYID_W-1:0]                            cmd_p2,
    input  logic [8*DATA_BYTES-1:0]                       cmd_data,
    output logic                                          cmd_ready,
    output logic                                          busy,
    output logic                                          rsp_valid,
    output logic [7:0]                                    rsp_status,
    output logic [KEYID_W-1:0]                            key_id,
    input  logic [KEY_W-1:0]                              key_data,
    output logic                                          sha_req,
    output logic [KEY_W+ONES_W+8*SEED_BYTES+LEN_W-1:0]    sha_msg,
    input  logic                                          sha_done,
    input  logic [8*DATA_BYTES-1:0]                       sha_digest,
    input  logic                                          wdt_expire,
    input  logic                                          sleep_req,
    output logic                                          mem_valid,
    output logic [8*DATA_BYTES-1:0]                       mac_secret
);
    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int SEED_W = 8 * SEED_BYTES;
    localparam int MSG_W  = KEY_W + ONES_W + SEED_W + LEN_W;

    kp_state_e               state_q, state_d;
    logic [7:0]              status_q, status_d;
    logic [SEED_W-2:0]       seed_q;
    logic [KEYID_W-1:0]      key_id_q;
    logic [MSG_W-1:0]        msg_q, msg_built;

    logic                    accept;
    logic                    abort;
    logic                    latch_seed;
    logic                    dig_capture;
    logic                    dig_discard;
    logic                    dig_ready;
    logic [DATA_W-1:0]       dig_value;
    logic                    sec_write;

    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign abort  = wdt_expire || sleep_req;

    kp_msg_builder #(
        .KEY_W  (KEY_W),
        .ONES_W (ONES_W),
        .SEED_W (SEED_W),
        .LEN_W  (LEN_W)
    ) u_msg (
        .key       (key_data),
        .seed_kept (seed_q),
        .msg       (msg_built)
    );

    kp_digest_store #(
        .DIG_W (DATA_W)
    ) u_dig (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (dig_capture),
        .capture_val (sha_digest),
        .discard     (dig_discard),
        .ready       (dig_ready),
        .value       (dig_value)
    );

    kp_secret_store #(
        .SEC_W (DATA_W)
    ) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sec_write),
        .wr_data (cmd_data ^ dig_value),
        .locked  (mem_valid),
        .value   (mac_secret)
    );

    // Next-state and datapath strobes
    always_comb begin
        state_d     = state_q;
        status_d    = status_q;
        latch_seed  = 1'b0;
        dig_capture = 1'b0;
        dig_discard = abort;
        sec_write   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (cmd_opcode)
                        OP_DERIVE: begin
                            if (cmd_p1 != 8'h00) begin
                                status_d = STS_PARAM;
                                state_d  = ST_REPLY;
                            end else begin
                                latch_seed  = 1'b1;
                                dig_discard = 1'b1;
                                state_d     = ST_FETCH;
                            end
                        end
                        OP_INSTALL: begin
                            state_d = ST_REPLY;
                            if (cmd_p1 != 8'h00 || cmd_p2 != '0) begin
                                status_d = STS_PARAM;
                            end else if (!dig_ready || mem_valid) begin
                                status_d    = STS_REFUSE;
                                dig_discard = 1'b1;
                            end else begin
                                status_d    = STS_OK;
                                sec_write   = 1'b1;
                                dig_discard = 1'b1;
                            end
                        end
                        default: begin
                            dig_discard = 1'b1;
                        end
                    endcase
                end
            end
            ST_FETCH: begin
                state_d = abort ? ST_IDLE : ST_HASH;
            end
            ST_HASH: begin
                if (abort) begin
                    state_d = sha_done ? ST_IDLE : ST_FLUSH;
                end else if (sha_done) begin
                    dig_capture = 1'b1;
                    status_d    = STS_OK;
                    state_d     = ST_REPLY;
                end
            end
            ST_FLUSH: begin
                if (sha_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= STS_OK;
            seed_q   <= '0;
            key_id_q <= '0;
            msg_q    <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            if (latch_seed) begin
                seed_q   <= cmd_data[DATA_W-1 -: SEED_W-1];
                key_id_q <= cmd_p2;
            end
            if (state_q == ST_FETCH) begin
                msg_q <= msg_built;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_ready  = 1'b0;
        busy       = 1'b0;
        sha_req    = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:  cmd_ready = 1'b1;
            ST_FETCH: busy      = 1'b1;
            ST_HASH: begin
                busy    = 1'b1;
                sha_req = 1'b1;
            end
            ST_FLUSH: begin
                busy    = 1'b1;
                sha_req = 1'b1;
            end
            ST_REPLY: rsp_valid = 1'b1;
            default:  cmd_ready = 1'b0;
        endcase
    end

    assign rsp_status = status_q;
    assign key_id     = key_id_q;
    assign sha_msg    = msg_q;
endmodule

// File: rtl/kp_personalize_checker.sv
module kp_personalize_checker #(
    parameter int W = 256
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_ready,
    input logic         busy,
    input logic         sha_req,
    input logic         sha_done,
    input logic         wdt_expire,
    input logic         sleep_req,
    input logic         rsp_valid,
    input logic [7:0]   rsp_status,
    input logic         mem_valid,
    input logic [W-1:0] mac_secret,
    input logic         dig_ready
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (cmd_ready && !busy && !rsp_valid && !sha_req && !mem_valid);
        end
    end

    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sha_req && !sha_done) |=> sha_req);

    assert_reply_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_ready) |-> (rsp_valid && rsp_status == 8'h00));

    assert_lock_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> (rsp_valid && rsp_status == 8'h00));

    assert_secret_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (mem_valid && $stable(mac_secret)));

    assert_abort_discards_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_expire || sleep_req) |=> !dig_ready);
endmodule

bind kp_personalize_ctrl kp_personalize_checker #(.W(8*DATA_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .sha_req    (sha_req),
    .sha_done   (sha_done),
    .wdt_expire (wdt_expire),
    .sleep_req  (sleep_req),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .mem_valid  (mem_valid),
    .mac_secret (mac_secret),
    .dig_ready  (dig_ready)
);

// File: tb/kp_personalize_ctrl_bench.sv
module kp_personalize_ctrl_bench;
    localparam int HASH_LAT = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [7:0]   cmd_opcode = '0;
    logic [7:0]   cmd_p1 = '0;
    logic [15:0]  cmd_p2 = '0;
    logic [255:0] cmd_data = '0;
    logic         cmd_ready, busy, rsp_valid, sha_req, mem_valid;
    logic [7:0]   rsp_status;
    logic [15:0]  key_id;
    logic [255:0] key_data;
    logic [511:0] sha_msg;
    logic         sha_done = 1'b0;
    logic [255:0] sha_digest = '0;
    logic         wdt_expire = 1'b0;
    logic         sleep_req = 1'b0;
    logic [255:0] mac_secret;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat_cnt = 0;

    always #4 clk = ~clk;

    kp_personalize_ctrl u_kp_personalize_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_p1(cmd_p1), .cmd_p2(cmd_p2), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .key_id(key_id),
        .key_data(key_data), .sha_req(sha_req), .sha_msg(sha_msg), .sha_done(sha_done),
        .sha_digest(sha_digest), .wdt_expire(wdt_expire), .sleep_req(sleep_req),
        .mem_valid(mem_valid), .mac_secret(mac_secret)
    );

    function automatic logic [255:0] key_of(input logic [15:0] id);
        return {8{id, ~id}};
    endfunction

    function automatic logic [255:0] dig_of(input logic [511:0] m);
        return m[511:256] ^ m[255:0] ^ {8{32'hC3A5_5A3C}};
    endfunction

    function automatic logic [511:0] exp_msg(input logic [15:0] id, input logic [255:0] d);
        return {key_of(id), 64'hFFFF_FFFF_FFFF_FFFF, d[255:129], 1'b1, 64'd447};
    endfunction

    assign key_data = key_of(key_id);

    // Hash engine model
    always @(posedge clk) begin
        if (sha_done) begin
            sha_done <= 1'b0;
        end else if (sha_req) begin
            if (lat_cnt == HASH_LAT) begin
                sha_done   <= 1'b1;
                sha_digest <= dig_of(sha_msg);
                lat_cnt    <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    logic         got_reply;
    logic [7:0]   last_status;
    logic         saw_req;
    logic         busy_bad;
    logic [511:0] req_msg;
    logic [15:0]  req_id;

    task automatic send(input logic [7:0] op, input logic [7:0] p1, input logic [15:0] p2,
                        input logic [255:0] d, input int wait_cycles);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = op; cmd_p1 = p1; cmd_p2 = p2; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_reply = 1'b0; saw_req = 1'b0; busy_bad = 1'b0; last_status = 8'hXX;
        for (int k = 0; k < wait_cycles; k++) begin
            if (rsp_valid) begin
                got_reply   = 1'b1;
                last_status = rsp_status;
                break;
            end
            if (sha_req) begin
                if (!saw_req) begin
                    req_msg = sha_msg;
                    req_id  = key_id;
                end
                saw_req = 1'b1;
                if (!busy || cmd_ready) busy_bad = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse(input bit use_sleep);
        @(negedge clk);
        if (use_sleep) sleep_req = 1'b1; else wdt_expire = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; wdt_expire = 1'b0;
    endtask

    logic [255:0] seed_a, payload, payload2, exp_secret;

    initial begin
        seed_a   = {8{32'h1357_9BDF}};
        payload  = {8{32'h0F1E_2D3C}};
        payload2 = {8{32'h5555_AAAA}};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 sha_req", sha_req, 0);
        chk("R1 mem_valid", mem_valid, 0);
        rst_n = 1'b1;

        // R6: install with no mask
        send(8'h10, 8'h00, 16'h0000, payload, 20);
        chk("R6 status", last_status, 8'h0F);
        chk("R6 mem_valid", mem_valid, 0);
        chk("R6 secret", mac_secret, 0);

        // R2/R3/R4: message layout sweep over selectors and dropped seed bit
        for (int i = 0; i < 8; i++) begin
            for (int b = 0; b < 2; b++) begin
                logic [15:0]  id;
                logic [255:0] d;
                id = 16'(i * 16'h2493 + 1);
                d  = seed_a ^ {8{16'(i), 16'(i)}};
                d[128] = b[0];
                send(8'h20, 8'h00, id, d, 40);
                chk("R2 key_id", req_id, id);
                chk("R2 sha_msg", req_msg, exp_msg(id, d));
                chk("R3 busy while hashing", {saw_req, busy_bad}, 2'b10);
                chk("R4 reply status", {got_reply, last_status}, {1'b1, 8'h00});
            end
        end

        // R8: every foreign opcode between derive and install
        for (int op = 0; op < 256; op++) begin
            if (op == 8'h20 || op == 8'h10) continue;
            send(8'h20, 8'h00, 16'h0042, seed_a, 40);
            chk("R4 derive ok", {got_reply, last_status}, {1'b1, 8'h00});
            send(8'(op), 8'h00, 16'h0000, payload, 6);
            chk("R8 no reply", got_reply, 0);
            send(8'h10, 8'h00, 16'h0000, payload, 20);
            chk("R8 install refused", last_status, 8'h0F);
        end
        chk("R8 secret untouched", {mem_valid, mac_secret}, 0);

        // R10: watchdog and sleep discard a ready mask
        for (int s = 0; s < 2; s++) begin
            send(8'h20, 8'h00, 16'h0007, seed_a, 40);
            pulse(s[0]);
            send(8'h10, 8'h00, 16'h0000, payload, 20);
            chk("R10 install after discard", last_status, 8'h0F);
        end

        // R11: abort during hash wait
        for (int s = 0; s < 2; s++) begin
            send(8'h20, 8'h00, 16'h0009, seed_a, 0);
            while (!sha_req) @(negedge clk);
            pulse(s[0]);
            got_reply = 1'b0;
            for (int k = 0; k < 30; k++) begin
                if (rsp_valid) got_reply = 1'b1;
                @(negedge clk);
            end
            chk("R11 no reply", got_reply, 0);
            chk("R11 back to idle", {cmd_ready, busy}, 2'b10);
            send(8'h10, 8'h00, 16'h0000, payload, 20);
            chk("R11 digest not kept", last_status, 8'h0F);
        end

        // R9: parameter violations keep the mask
        send(8'h20, 8'h00, 16'h0033, seed_a, 40);
        chk("R4 derive ok", last_status, 8'h00);
        for (int p = 1; p < 256; p++) begin
            send(8'h20, 8'(p), 16'h0033, seed_a, 20);
            chk("R9 derive p1", {last_status, saw_req}, {8'h03, 1'b0});
        end
        for (int p = 0; p < 8; p++) begin
            send(8'h10, 8'(1 << p), 16'h0000, payload, 20);
            chk("R9 install p1", last_status, 8'h03);
        end
        for (int p = 0; p < 16; p++) begin
            send(8'h10, 8'h00, 16'(1 << p), payload, 20);
            chk("R9 install p2", last_status, 8'h03);
        end
        chk("R9 secret untouched", mem_valid, 0);

        // R5: install uses the kept mask
        exp_secret = payload ^ dig_of(exp_msg(16'h0033, seed_a));
        send(8'h10, 8'h00, 16'h0000, payload, 20);
        chk("R5 status", {got_reply, last_status}, {1'b1, 8'h00});
        chk("R5 mem_valid", mem_valid, 1);
        chk("R5 secret", mac_secret, exp_secret);

        // R7: lock holds
        send(8'h20, 8'h00, 16'h0044, seed_a, 40);
        send(8'h10, 8'h00, 16'h0000, payload2, 20);
        chk("R7 install refused", last_status, 8'h0F);
        pulse(1'b0);
        pulse(1'b1);
        @(negedge clk);
        chk("R7 secret kept", mac_secret, exp_secret);
        chk("R7 mem_valid kept", mem_valid, 1);

        finish_run();
    end
endmodule